// File: doc/BRIEF.md
# DMA Completion Chaining Controller

This block handles event and completion sequencing for a small DMA engine. Each channel holds a record with a remaining array count, a transfer-complete code (a channel index), a chaining mode and a completion-report choice. Two kinds of trigger start an array transfer on a channel. The first is an external synchronization event. The second is a chained event raised when another channel finishes an array. The block sends one array-transfer request at a time to an external data mover over a valid/ready handshake. The mover answers with a done pulse.

When an array finishes, the block decrements the channel's count. It can then set the chained-event bit indexed by the transfer-complete code. This can happen after every array except the last, after the last array, or both. A channel with completion reporting sets the interrupt-pending bit indexed by its code when its last array finishes. The CPU interrupt is raised when a pending bit and its enable bit are both set. In the typical use, one external event on an input-stream channel also triggers an output-stream channel, so the two streams advance in lockstep.

Top module: `dma_chain_ctrl`

## Requirements
- R1: Each accepted request moves one array. Each done pulse lowers the count of the channel being served by one. A channel configured with count N is granted exactly N transfers.
- R2: If chaining-mode bit 0 (intermediate) is set, a done pulse that leaves a non-zero count sets chain_pend[tcc] on the next clock edge.
- R3: If chaining-mode bit 1 (final) is set, the done pulse that brings the count to zero sets chain_pend[tcc]. Bit 0 has no effect on that last array.
- R4: A set chain_pend bit of an active channel requests a transfer for that channel in the same way as an external event. The bit clears when that request is accepted.
- R5: When a channel with cfg_report=1 finishes its last array, int_pend[tcc] is set. A pending bit clears only when the matching ipr_clr bit is 1, and other ipr_clr bits leave it unchanged.
- R6: irq is 1 exactly when some bit is set in both int_pend and ier.
- R7: Among pending channels, the lowest-numbered one is requested first. req_valid stays low from acceptance until the done pulse, so only one transfer is outstanding.
- R8: A channel is active while its count is non-zero. Loading a count of 0 makes it inactive, and so does finishing its last array. Events to an inactive channel are dropped and produce no request.
- R9: If an event arrives for a channel whose own bit of the same kind is already set and is not being consumed, missed for that channel is set. It stays set until that channel is reconfigured.
- R10: The external-event bit and the chained-event bit of a channel are held separately. An accept consumes the external bit first, so one external event and one chained event give two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a channel record |
| cfg_ch | input | CH_W | Channel being configured |
| cfg_cnt | input | CNT_W | Array count; 0 leaves the channel inactive |
| cfg_tcc | input | CH_W | Transfer-complete code (target channel index) |
| cfg_mode | input | 2 | Chaining mode: bit 0 intermediate, bit 1 final |
| cfg_report | input | 1 | Set the pending bit on final completion |
| ext_evt | input | NUM_CH | External synchronization event pulses |
| req_valid | output | 1 | Array-transfer request |
| req_ready | input | 1 | Data mover accepts the request |
| req_ch | output | CH_W | Channel of the request |
| xfer_done | input | 1 | Outstanding array finished |
| ier | input | NUM_CH | Interrupt enable per pending bit |
| ipr_clr | input | NUM_CH | Write-one-to-clear for pending bits |
| chain_pend | output | NUM_CH | Chained-event bits |
| int_pend | output | NUM_CH | Interrupt-pending bits |
| irq | output | 1 | CPU interrupt |
| missed | output | NUM_CH | Sticky missed-event flags |
| active | output | NUM_CH | Channel has arrays remaining |

## Verification
The hardest case to reach from the ports is a channel that already holds an event bit and receives another event of the same kind. An intermediate chained event can also land on a target that still has an external event waiting. The bench reaches both by holding req_ready low while it sends repeated events, and by sending one external pulse to a source channel and its target together. It then counts grants per channel over a sweep of every chaining mode against array counts 1 to 4, and compares the counts with totals worked out from the mode and count.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   typedef enum logic [1:0] {
      CHAIN_OFF   = 2'b00,
      CHAIN_INTER = 2'b01,
      CHAIN_FINAL = 2'b10,
      CHAIN_BOTH  = 2'b11
   } chain_mode_e;

   function automatic logic mode_inter(input chain_mode_e m);
      return (m == CHAIN_INTER) || (m == CHAIN_BOTH);
   endfunction

   function automatic logic mode_final(input chain_mode_e m);
      return (m == CHAIN_FINAL) || (m == CHAIN_BOTH);
   endfunction
endpackage

// File: rtl/dcc_prio_pick.sv
module dcc_prio_pick #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("dcc_prio_pick: N must be at least 2");
   end
   if ((1 << W) < N) begin : g_bad_w
      $error("dcc_prio_pick: W too narrow for N");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/dcc_chan_ctx.sv
module dcc_chan_ctx
   import dcc_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int CH_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] ld_cnt,
   input  logic [CH_W-1:0]  ld_tcc,
   input  logic [1:0]       ld_mode,
   input  logic             ld_report,
   input  logic             dec,
   output logic             active,
   output logic             last,
   output logic [CH_W-1:0]  tcc,
   output logic             inter_en,
   output logic             final_en,
   output logic             report
);
   logic [CNT_W-1:0] cnt_q;
   logic [CH_W-1:0]  tcc_q;
   chain_mode_e      mode_q;
   logic             rep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tcc_q  <= '0;
         mode_q <= CHAIN_OFF;
         rep_q  <= 1'b0;
      end else if (load) begin
         cnt_q  <= ld_cnt;
         tcc_q  <= ld_tcc;
         mode_q <= chain_mode_e'(ld_mode);
         rep_q  <= ld_report;
      end else if (dec && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active   = (cnt_q != '0);
   assign last     = (cnt_q == CNT_W'(1));
   assign tcc      = tcc_q;
   assign inter_en = mode_inter(mode_q);
   assign final_en = mode_final(mode_q);
   assign report   = rep_q;

   // R1: a completion only ever lands on a channel with arrays remaining
   assert_dec_on_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> cnt_q != '0);

   // R8: finishing the last array leaves the channel inactive
   assert_last_deactivates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && last && !load) |=> !active);
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 8,
   parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic [CH_W-1:0]   cfg_tcc,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_report,
   input  logic [NUM_CH-1:0] ext_evt,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [CH_W-1:0]   req_ch,
   input  logic              xfer_done,
   input  logic [NUM_CH-1:0] ier,
   input  logic [NUM_CH-1:0] ipr_clr,
   output logic [NUM_CH-1:0] chain_pend,
   output logic [NUM_CH-1:0] int_pend,
   output logic              irq,
   output logic [NUM_CH-1:0] missed,
   output logic [NUM_CH-1:0] active
);
   localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("dma_chain_ctrl: NUM_CH must be at least 2");
   end
   if ((1 << CH_W) < NUM_CH) begin : g_bad_chw
      $error("dma_chain_ctrl: CH_W too narrow for NUM_CH");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("dma_chain_ctrl: CNT_W must be positive");
   end

   // per-channel record outputs
   logic [NUM_CH-1:0] act_v, last_v, inter_v, final_v, rep_v;
   logic [CH_W-1:0]   tcc_v [NUM_CH];
   logic [NUM_CH-1:0] done_v;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dcc_chan_ctx #(.CNT_W(CNT_W), .CH_W(CH_W)) u_ctx (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (cfg_we && cfg_ch == CH_W'(c)),
         .ld_cnt    (cfg_cnt),
         .ld_tcc    (cfg_tcc),
         .ld_mode   (cfg_mode),
         .ld_report (cfg_report),
         .dec       (done_v[c]),
         .active    (act_v[c]),
         .last      (last_v[c]),
         .tcc       (tcc_v[c]),
         .inter_en  (inter_v[c]),
         .final_en  (final_v[c]),
         .report    (rep_v[c])
      );
   end

   // event and status state
   logic [NUM_CH-1:0] ext_q, cer_q, ipr_q, miss_q;
   logic              busy_q;
   logic [CH_W-1:0]   cur_q;

   // arbitration
   logic [NUM_CH-1:0] pend;
   logic              pick_any;
   logic [CH_W-1:0]   pick_idx;
   logic              accept;

   assign pend = (ext_q | cer_q) & act_v;

   dcc_prio_pick #(.N(NUM_CH), .W(CH_W)) u_pick (
      .req (pend),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign req_valid = pick_any && !busy_q;
   assign req_ch    = pick_idx;
   assign accept    = req_valid && req_ready;

   // completion effects
   logic [NUM_CH-1:0] sel_oh, clr_ext, clr_cer;
   logic [NUM_CH-1:0] chain_set, ipr_set, fin_v, cfg_oh, act_after;
   logic [NUM_CH-1:0] ext_in, cer_in, miss_set;

   always_comb begin
      sel_oh  = ONE << pick_idx;
      clr_ext = accept ? (sel_oh & ext_q) : '0;
      clr_cer = accept ? (sel_oh & ~ext_q & cer_q) : '0;
      done_v  = (xfer_done && busy_q) ? (ONE << cur_q) : '0;
      fin_v   = done_v & last_v;
      cfg_oh  = cfg_we ? (ONE << cfg_ch) : '0;

      chain_set = '0;
      ipr_set   = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (done_v[c]) begin
            if (last_v[c]) begin
               if (final_v[c]) chain_set = chain_set | (ONE << tcc_v[c]);
               if (rep_v[c])   ipr_set   = ipr_set   | (ONE << tcc_v[c]);
            end else if (inter_v[c]) begin
               chain_set = chain_set | (ONE << tcc_v[c]);
            end
         end
      end

      act_after = (act_v & ~fin_v & ~cfg_oh) | (cfg_we && cfg_cnt != '0 ? cfg_oh : '0);
      ext_in    = ext_evt & act_v;
      cer_in    = chain_set & act_v;
      miss_set  = (ext_in & ext_q & ~clr_ext) | (cer_in & cer_q & ~clr_cer);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q  <= '0;
         cer_q  <= '0;
         ipr_q  <= '0;
         miss_q <= '0;
         busy_q <= 1'b0;
         cur_q  <= '0;
      end else begin
         ext_q  <= ((ext_q & ~clr_ext) | ext_in) & act_after;
         cer_q  <= ((cer_q & ~clr_cer) | cer_in) & act_after;
         ipr_q  <= (ipr_q & ~ipr_clr) | ipr_set;
         miss_q <= (miss_q & ~cfg_oh) | miss_set;
         if (accept) begin
            busy_q <= 1'b1;
            cur_q  <= pick_idx;
         end else if (xfer_done) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign chain_pend = cer_q;
   assign int_pend   = ipr_q;
   assign irq        = |(ipr_q & ier);
   assign missed     = miss_q;
   assign active     = act_v;

   // R7: no new request while a transfer is outstanding
   assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !req_valid);

   // R7: accepting a request holds off the next one for at least a cycle
   assert_accept_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_valid);

   // R2: a chained-event bit only appears after a done pulse
   assert_chain_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cer_q & ~$past(cer_q)) != '0 |-> $past(xfer_done));

   // R5: a pending bit only appears after a done pulse
   assert_pend_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ipr_q & ~$past(ipr_q)) != '0 |-> $past(xfer_done));

   // R5: a pending bit only drops under its own clear strobe
   assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ipr_q) & ~$past(ipr_clr) & ~ipr_q) == '0);

   // R9: the missed flags only drop on reconfiguration
   assert_missed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> ($past(miss_q) & ~miss_q) == '0);
endmodule

// File: tb/tb_dma_chain_ctrl.sv
module tb_dma_chain_ctrl;
   localparam int NCH = 4;
   localparam int CW  = 2;
   localparam int NW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [CW-1:0] cfg_ch = '0;
   logic [NW-1:0] cfg_cnt = '0;
   logic [CW-1:0] cfg_tcc = '0;
   logic [1:0]    cfg_mode = '0;
   logic          cfg_report = 1'b0;
   logic [NCH-1:0] ext_evt = '0;
   logic          req_valid;
   logic          req_ready = 1'b0;
   logic [CW-1:0] req_ch;
   logic          xfer_done = 1'b0;
   logic [NCH-1:0] ier = '0;
   logic [NCH-1:0] ipr_clr = '0;
   logic [NCH-1:0] chain_pend, int_pend, missed, active;
   logic          irq;

   int nchk = 0;
   int nerr = 0;
   int g [NCH];

   always #10 clk = ~clk;

   dma_chain_ctrl #(.NUM_CH(NCH), .CNT_W(NW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_cnt(cfg_cnt),
      .cfg_tcc(cfg_tcc), .cfg_mode(cfg_mode), .cfg_report(cfg_report),
      .ext_evt(ext_evt), .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch),
      .xfer_done(xfer_done), .ier(ier), .ipr_clr(ipr_clr), .chain_pend(chain_pend),
      .int_pend(int_pend), .irq(irq), .missed(missed), .active(active)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_g();
      for (int i = 0; i < NCH; i++) g[i] = 0;
   endtask

   task automatic cfg(input int ch, input int cnt, input int tcc, input int mode, input bit rep);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = CW'(ch); cfg_cnt = NW'(cnt);
      cfg_tcc = CW'(tcc); cfg_mode = 2'(mode); cfg_report = rep;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input logic [NCH-1:0] m);
      @(negedge clk);
      ext_evt = m;
      @(negedge clk);
      ext_evt = '0;
   endtask

   task automatic serve_one(output int ch);
      ch = -1;
      for (int w = 0; w < 4; w++) begin
         if (req_valid) break;
         @(negedge clk);
      end
      if (req_valid) begin
         ch = int'(req_ch);
         g[ch]++;
         req_ready = 1'b1;
         @(negedge clk);
         req_ready = 1'b0;
         chk("R7 busy blocks req_valid", int'(req_valid), 0);
         xfer_done = 1'b1;
         @(negedge clk);
         xfer_done = 1'b0;
      end
   endtask

   task automatic serve_all();
      int c;
      for (int k = 0; k < 40; k++) begin
         serve_one(c);
         if (c < 0) break;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R8 reset active", int'(active), 0);
      chk("R7 reset req_valid", int'(req_valid), 0);
      chk("R5 reset int_pend", int'(int_pend), 0);
      chk("R6 reset irq", int'(irq), 0);

      // R8: count 0 leaves channel inactive, events dropped
      cfg(3, 0, 3, 0, 0);
      pulse(4'b1000);
      @(negedge clk);
      chk("R8 inactive no request", int'(req_valid), 0);
      chk("R8 inactive flag", int'(active[3]), 0);

      // R2/R3/R1 sweep: every mode against counts 1..4
      for (int mode = 0; mode < 4; mode++) begin
         for (int n = 1; n <= 4; n++) begin
            int exp2;
            cfg(0, n, 2, mode, 0);
            cfg(2, 20, 3, 0, 1);
            clr_g();
            for (int k = 0; k < n; k++) begin
               pulse(4'b0001);
               serve_all();
            end
            exp2 = ((mode & 1) != 0 ? n - 1 : 0) + ((mode & 2) != 0 ? 1 : 0);
            chk("R1 source grants", g[0], n);
            chk("R2 R3 chained grants", g[2], exp2);
            chk("R8 source done inactive", int'(active[0]), 0);
            chk("R5 no pending before final", int'(int_pend), 0);
         end
      end

      // R4: chained bit requests target, clears on accept
      cfg(0, 3, 2, 1, 0);
      cfg(2, 20, 3, 0, 0);
      pulse(4'b0001);
      serve_one(c);
      chk("R2 chain_pend after intermediate", int'(chain_pend), 4);
      chk("R4 chained request channel", int'(req_ch), 2);
      serve_one(c);
      chk("R4 chained target served", c, 2);
      chk("R4 chain_pend cleared", int'(chain_pend), 0);

      // R7: lowest-numbered first
      cfg(1, 5, 1, 0, 0);
      cfg(3, 5, 3, 0, 0);
      pulse(4'b1010);
      serve_one(c);
      chk("R7 lowest first", c, 1);
      serve_one(c);
      chk("R7 next channel", c, 3);

      // R10: external and chained bits on one channel give two transfers
      cfg(0, 3, 2, 1, 0);
      cfg(2, 20, 3, 0, 0);
      clr_g();
      pulse(4'b0101);
      serve_all();
      chk("R10 target two transfers", g[2], 2);
      chk("R10 source one transfer", g[0], 1);

      // R9: repeated event while bit set
      cfg(1, 5, 1, 0, 0);
      chk("R9 cleared by reconfig", int'(missed[1]), 0);
      clr_g();
      pulse(4'b0010);
      pulse(4'b0010);
      chk("R9 missed set", int'(missed[1]), 1);
      serve_all();
      chk("R9 single transfer", g[1], 1);
      chk("R9 sticky", int'(missed[1]), 1);
      cfg(1, 5, 1, 0, 0);
      chk("R9 reconfig clears", int'(missed[1]), 0);

      // R5/R6: pending indexed by tcc, enable gating, W1C
      cfg(1, 2, 3, 0, 1);
      pulse(4'b0010);
      serve_all();
      chk("R5 not after first array", int'(int_pend), 0);
      pulse(4'b0010);
      serve_all();
      chk("R5 pending at tcc", int'(int_pend), 8);
      chk("R6 irq disabled", int'(irq), 0);
      ier = 4'b1000; #1;
      chk("R6 irq enabled", int'(irq), 1);
      ier = 4'b0100; #1;
      chk("R6 irq other enable", int'(irq), 0);
      ier = 4'b1000;
      @(negedge clk);
      ipr_clr = 4'b0100;
      @(negedge clk);
      ipr_clr = '0;
      chk("R5 other clear no effect", int'(int_pend), 8);
      ipr_clr = 4'b1000;
      @(negedge clk);
      ipr_clr = '0;
      chk("R5 W1C clears", int'(int_pend), 0);
      chk("R6 irq drops", int'(irq), 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule